// File: doc/BRIEF.md
# Wide-Word Pixel Fetch Port

This block sits between a single-ported frame memory and two users: a display path that needs one pixel every clock, and a host that reads and writes single bytes. A memory word carries several pixels side by side. The display path fetches a whole word in one access, holds it in a local buffer and hands out its pixels one per clock. Because only one memory access in every `PIX_PER_WORD` cycles goes to the display, the remaining cycles are available to the host.

A host access names a byte: the word address sits in the upper address bits and the lane number sits in the low bits. Reads return the selected lane of the word. Writes are carried out in one of two ways, chosen by a parameter. If the memory has per-lane write enables, the write is a single access with one enable bit set. If it does not, the write becomes a read of the full word, a merge of the new byte, and a write-back of the full word. That read-merge-write sequence is never split by a display fetch.

The display fetches the next word while it is still showing the current one, so the pixel stream has no gaps. The memory returns read data in the cycle after a read is issued.

Top module: `wide_pixel_port`

## Requirements
- R1: A memory word of `PIX_W*PIX_PER_WORD` bits holds pixel i in bits `[i*PIX_W +: PIX_W]`, so pixel 0 is the least significant lane and is shown first.
- R2: Pixels are issued in order 0 to `PIX_PER_WORD-1` of frame word w, then those of word w+1. After word `DISP_WORDS-1` the sequence continues at word 0.
- R3: After reset, `pix_valid`, `host_ack` and `mem_req` are low. When `disp_en` goes high with the host idle, the first pixel of word 0 is valid two cycles later. When `disp_en` is low, `pix_valid` is low from the next cycle, and a later enable starts again at word 0.
- R4: Once `pix_valid` is high, it stays high every cycle for as long as `disp_en` stays high, whatever host traffic is present.
- R5: The display has priority for the memory. A host request waits while a display fetch is due, and the two users never issue an access in the same cycle.
- R6: Host byte address = {word, lane}, with the lane number in the low `log2(LANES)` bits. A read returns that lane of the word on `host_rdata`, together with `host_ack`.
- R7: With byte enables (`USE_BYTE_EN`=1), a host write is a single memory write with only the addressed lane's enable bit set, acknowledged in the cycle it is issued. The other lanes of the word keep their values.
- R8: Without byte enables (`USE_BYTE_EN`=0), a host write is a read of the word followed in the next cycle by a write of the full word with every enable bit set. In that word only the addressed lane changes. `host_ack` comes with the write.
- R9: The read and write-back of a read-merge-write go to the same word in consecutive cycles with no display access between them. The sequence is started only when the following cycle is not a display fetch slot.
- R10: `host_ack` is high only while `host_req` is high, and it pulses once per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pixel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en | input | 1 | Display streaming enable |
| pix_valid | output | 1 | Pixel output valid |
| pix_data | output | PIX_W | Current pixel |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W+log2(LANES) | Host byte address {word, lane} |
| host_wdata | input | LANE_W | Host write byte |
| host_ack | output | 1 | Host transaction complete |
| host_rdata | output | LANE_W | Host read byte, valid with ack |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | LANES | Memory lane write enables |
| mem_wdata | output | PIX_W*PIX_PER_WORD | Memory write word |
| mem_rdata | input | PIX_W*PIX_PER_WORD | Memory read word, one cycle after a read |

## Verification
The hardest case to reach is a host write without byte enables that arrives just before a display fetch slot. A read-merge-write started there would collide with the prefetch, so the block must hold it back for a cycle without dropping a pixel. To reach this case, the stimulus sends host reads and writes to words outside the displayed frame while the display streams, and varies the idle gap between requests from zero to four cycles. Each request therefore lands on every phase of the pixel counter. A cycle-by-cycle model of the expected pixel stream is checked every clock during this traffic, and every word the host writes is compared against a byte-merged shadow copy.

// File: rtl/wpp_pkg.sv
package wpp_pkg;
    typedef enum logic [1:0] {
        H_IDLE,
        H_RD_WAIT,
        H_RMW_WR
    } host_st_e;
endpackage

// File: rtl/wpp_lane.sv
// Byte-lane steering: lane decode, write replication, merge and read select.
module wpp_lane #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = WORD_W / LANE_W,
    localparam int LSEL_W = $clog2(LANES)
) (
    input  logic [LSEL_W-1:0] lane_sel,
    input  logic [LANE_W-1:0] wbyte,
    input  logic [WORD_W-1:0] rword,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] merged,
    output logic [LANE_W-1:0] rbyte
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = (lane_sel == LSEL_W'(g));
        assign wword[g*LANE_W +: LANE_W] = wbyte;
        assign merged[g*LANE_W +: LANE_W] = be[g] ? wbyte : rword[g*LANE_W +: LANE_W];
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) rbyte = rword[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/wpp_disp.sv
// Display side: word buffer, pixel sequencer and prefetch slot.
module wpp_disp #(
    parameter int PIX_W = 8,
    parameter int PPW = 4,
    parameter int ADDR_W = 6,
    parameter int DISP_WORDS = 8,
    localparam int WORD_W = PIX_W * PPW,
    localparam int IDX_W = $clog2(PPW),
    localparam int LAST = PPW - 1,
    localparam int SLOT = PPW - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_en,
    input  logic              fill_blk,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              fetch,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              slot_next,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data
);
    typedef struct packed {
        logic              run;
        logic              pend;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] ptr;
        logic [WORD_W-1:0] buff;
    } disp_s;

    disp_s s_d, s_q;
    logic [IDX_W-1:0] idx_inc;

    always_comb begin
        s_d = s_q;
        idx_inc = (s_q.idx == IDX_W'(LAST)) ? '0 : s_q.idx + 1'b1;
        fetch = disp_en && ((s_q.run && s_q.idx == IDX_W'(SLOT)) ||
                            (!s_q.run && !s_q.pend && !fill_blk));
        slot_next = disp_en && ((s_q.run && idx_inc == IDX_W'(SLOT)) ||
                                (!s_q.run && s_q.pend && SLOT == 0));
        if (!disp_en) begin
            s_d.run  = 1'b0;
            s_d.pend = 1'b0;
            s_d.idx  = '0;
            s_d.ptr  = '0;
        end else begin
            s_d.pend = fetch;
            if (fetch) begin
                s_d.ptr = (s_q.ptr == ADDR_W'(DISP_WORDS - 1)) ? '0 : s_q.ptr + 1'b1;
            end
            if (s_q.pend) s_d.buff = mem_rdata;
            if (s_q.run) begin
                s_d.idx = idx_inc;
            end else if (s_q.pend) begin
                s_d.run = 1'b1;
                s_d.idx = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fetch_addr = s_q.ptr;
    assign pix_valid  = s_q.run;

    always_comb begin
        pix_data = '0;
        for (int i = 0; i < PPW; i++) begin
            if (s_q.idx == IDX_W'(i)) pix_data = s_q.buff[i*PIX_W +: PIX_W];
        end
    end
endmodule

// File: rtl/wpp_host.sv
// Host side: byte access sequencer with byte-enable or read-merge-write writes.
module wpp_host #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 6,
    parameter int USE_BE = 1,
    localparam int LANES = WORD_W / LANE_W,
    localparam int LSEL_W = $clog2(LANES),
    localparam int HA_W = ADDR_W + LSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [LANE_W-1:0] host_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              disp_fetch,
    input  logic              disp_slot_next,
    output logic              host_ack,
    output logic [LANE_W-1:0] host_rdata,
    output logic              h_req,
    output logic              h_we,
    output logic [ADDR_W-1:0] h_addr,
    output logic [LANES-1:0]  h_be,
    output logic [WORD_W-1:0] h_wdata,
    output logic              rmw_wr
);
    import wpp_pkg::*;

    typedef struct packed {
        host_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [LSEL_W-1:0] lane;
        logic [LANE_W-1:0] wbyte;
    } host_s;

    host_s s_d, s_q;
    logic [LSEL_W-1:0] lane_sel;
    logic [LANE_W-1:0] wbyte;
    logic [LANES-1:0]  be;
    logic [WORD_W-1:0] wword, merged;

    assign lane_sel = (s_q.st == H_IDLE) ? host_addr[LSEL_W-1:0] : s_q.lane;
    assign wbyte    = (s_q.st == H_IDLE) ? host_wdata : s_q.wbyte;

    wpp_lane #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_lane (
        .lane_sel(lane_sel),
        .wbyte   (wbyte),
        .rword   (mem_rdata),
        .be      (be),
        .wword   (wword),
        .merged  (merged),
        .rbyte   (host_rdata)
    );

    always_comb begin
        s_d      = s_q;
        host_ack = 1'b0;
        h_req    = 1'b0;
        h_we     = 1'b0;
        h_addr   = host_addr[LSEL_W +: ADDR_W];
        h_be     = '0;
        h_wdata  = '0;
        case (s_q.st)
            H_IDLE: begin
                if (host_req && !disp_fetch) begin
                    s_d.addr  = host_addr[LSEL_W +: ADDR_W];
                    s_d.lane  = host_addr[LSEL_W-1:0];
                    s_d.wbyte = host_wdata;
                    if (!host_we) begin
                        h_req  = 1'b1;
                        s_d.st = H_RD_WAIT;
                    end else if (USE_BE != 0) begin
                        h_req    = 1'b1;
                        h_we     = 1'b1;
                        h_be     = be;
                        h_wdata  = wword;
                        host_ack = 1'b1;
                    end else if (!disp_slot_next) begin
                        h_req  = 1'b1;
                        s_d.st = H_RMW_WR;
                    end
                end
            end
            H_RD_WAIT: begin
                host_ack = 1'b1;
                s_d.st   = H_IDLE;
            end
            H_RMW_WR: begin
                h_req    = 1'b1;
                h_we     = 1'b1;
                h_be     = '1;
                h_addr   = s_q.addr;
                h_wdata  = merged;
                host_ack = 1'b1;
                s_d.st   = H_IDLE;
            end
            default: s_d.st = H_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= H_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rmw_wr = (s_q.st == H_RMW_WR);
endmodule

// File: rtl/wide_pixel_port.sv
module wide_pixel_port #(
    parameter int PIX_W = 8,
    parameter int PIX_PER_WORD = 4,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 6,
    parameter int DISP_WORDS = 8,
    parameter int USE_BYTE_EN = 1,
    localparam int WORD_W = PIX_W * PIX_PER_WORD,
    localparam int LANES = WORD_W / LANE_W,
    localparam int LSEL_W = $clog2(LANES),
    localparam int HA_W = ADDR_W + LSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_en,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [LANE_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [LANE_W-1:0] host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic              d_fetch, d_slot_next, rmw_wr;
    logic [ADDR_W-1:0] d_addr;
    logic              h_req, h_we;
    logic [ADDR_W-1:0] h_addr;
    logic [LANES-1:0]  h_be;
    logic [WORD_W-1:0] h_wdata;

    wpp_disp #(
        .PIX_W(PIX_W), .PPW(PIX_PER_WORD), .ADDR_W(ADDR_W), .DISP_WORDS(DISP_WORDS)
    ) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_en   (disp_en),
        .fill_blk  (rmw_wr),
        .mem_rdata (mem_rdata),
        .fetch     (d_fetch),
        .fetch_addr(d_addr),
        .slot_next (d_slot_next),
        .pix_valid (pix_valid),
        .pix_data  (pix_data)
    );

    wpp_host #(
        .WORD_W(WORD_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .USE_BE(USE_BYTE_EN)
    ) u_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_req      (host_req),
        .host_we       (host_we),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .mem_rdata     (mem_rdata),
        .disp_fetch    (d_fetch),
        .disp_slot_next(d_slot_next),
        .host_ack      (host_ack),
        .host_rdata    (host_rdata),
        .h_req         (h_req),
        .h_we          (h_we),
        .h_addr        (h_addr),
        .h_be          (h_be),
        .h_wdata       (h_wdata),
        .rmw_wr        (rmw_wr)
    );

    // Display fetch owns the memory whenever it is due.
    always_comb begin
        mem_req   = d_fetch | h_req;
        mem_we    = d_fetch ? 1'b0 : h_we;
        mem_addr  = d_fetch ? d_addr : h_addr;
        mem_be    = d_fetch ? '0 : h_be;
        mem_wdata = d_fetch ? '0 : h_wdata;
    end
endmodule

// File: rtl/wpp_chk.sv
module wpp_chk #(
    parameter int LANES = 4,
    parameter int ADDR_W = 6,
    parameter int USE_BE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_en,
    input logic              pix_valid,
    input logic              host_req,
    input logic              host_we,
    input logic              host_ack,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic              d_fetch,
    input logic              h_req
);
    p_no_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && disp_en |=> pix_valid);

    p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> !pix_valid);

    p_one_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_fetch && h_req));

    p_be_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_BE != 0) && mem_req && mem_we |-> $onehot(mem_be));

    p_rmw_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_BE == 0) && mem_req && mem_we |-> (&mem_be));

    p_rmw_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_BE == 0) && h_req && !mem_we && host_req && host_we
        |=> mem_req && mem_we && !d_fetch && (mem_addr == $past(mem_addr)));

    p_ack_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> host_req);
endmodule

bind wide_pixel_port wpp_chk #(
    .LANES(LANES), .ADDR_W(ADDR_W), .USE_BE(USE_BYTE_EN)
) u_wpp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .disp_en  (disp_en),
    .pix_valid(pix_valid),
    .host_req (host_req),
    .host_we  (host_we),
    .host_ack (host_ack),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .d_fetch  (d_fetch),
    .h_req    (h_req)
);

// File: tb/test_wide_pixel_port.sv
`timescale 1ns/1ps
module test_wide_pixel_port;
    localparam int PIX_W = 8;
    localparam int PPW = 4;
    localparam int ADDR_W = 6;
    localparam int DW = 8;
    localparam int WORDS = 64;
    localparam int HA_W = ADDR_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              disp_en[2], pix_valid[2], host_req[2], host_we[2], host_ack[2];
    logic              mem_req[2], mem_we[2];
    logic [7:0]        pix_data[2], host_wdata[2], host_rdata[2];
    logic [HA_W-1:0]   host_addr[2];
    logic [ADDR_W-1:0] mem_addr[2];
    logic [3:0]        mem_be[2];
    logic [31:0]       mem_wdata[2], mem_rdata[2], rd_q[2];
    logic [31:0]       mem[2][WORDS];
    logic [31:0]       exp_mem[2][WORDS];

    int checks = 0;
    int fails = 0;
    int k[2];
    bit done = 0;

    // Instance 0 uses byte enables, instance 1 uses read-merge-write.
    for (genvar m = 0; m < 2; m++) begin : g_dut
        wide_pixel_port #(
            .PIX_W(PIX_W), .PIX_PER_WORD(PPW), .LANE_W(8), .ADDR_W(ADDR_W),
            .DISP_WORDS(DW), .USE_BYTE_EN(m == 0 ? 1 : 0)
        ) i_wide_pixel_port (
            .clk(clk), .rst_n(rst_n), .disp_en(disp_en[m]),
            .pix_valid(pix_valid[m]), .pix_data(pix_data[m]),
            .host_req(host_req[m]), .host_we(host_we[m]), .host_addr(host_addr[m]),
            .host_wdata(host_wdata[m]), .host_ack(host_ack[m]), .host_rdata(host_rdata[m]),
            .mem_req(mem_req[m]), .mem_we(mem_we[m]), .mem_addr(mem_addr[m]),
            .mem_be(mem_be[m]), .mem_wdata(mem_wdata[m]), .mem_rdata(mem_rdata[m])
        );
    end

    // Frame memory models: one-cycle read latency, per-lane write enables.
    always_ff @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                for (int a = 0; a < WORDS; a++) mem[m][a] <= '0;
                rd_q[m] <= '0;
            end else begin
                if (mem_req[m] && mem_we[m]) begin
                    for (int l = 0; l < 4; l++) begin
                        if (mem_be[m][l]) mem[m][mem_addr[m]][l*8 +: 8] <= mem_wdata[m][l*8 +: 8];
                    end
                end
                if (mem_req[m] && !mem_we[m]) rd_q[m] <= mem[m][mem_addr[m]];
            end
        end
    end
    always_comb for (int m = 0; m < 2; m++) mem_rdata[m] = rd_q[m];

    task automatic check(bit ok, string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // Cycle reference model of the pixel stream (R1 R2 R3 R4 R5), checked every clock.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            for (int m = 0; m < 2; m++) begin
                bit ev;
                ev = (k[m] >= 2);
                check(pix_valid[m] == ev, $sformatf("R3 R4 R5 m=%0d pix_valid got %0d exp %0d",
                      m, pix_valid[m], ev));
                if (ev) begin
                    int p, w, l;
                    logic [7:0] ep;
                    p  = k[m] - 2;
                    w  = (p / PPW) % DW;
                    l  = p % PPW;
                    ep = exp_mem[m][w][l*8 +: 8];
                    check(pix_data[m] === ep, $sformatf("R1 R2 m=%0d pixel %0d got %02h exp %02h",
                          m, p, pix_data[m], ep));
                end
                if (host_ack[m] && !host_req[m]) check(0, $sformatf("R10 m=%0d ack got 1 exp 0", m));
                k[m] = disp_en[m] ? k[m] + 1 : 0;
            end
        end
    end

    task automatic host_op(int m, bit we, int word, int lane, logic [7:0] wd);
        logic [7:0] rd;
        logic [7:0] eb;
        @(negedge clk);
        host_req[m]   = 1'b1;
        host_we[m]    = we;
        host_addr[m]  = HA_W'(word * 4 + lane);
        host_wdata[m] = wd;
        #1;
        while (!host_ack[m]) begin
            @(negedge clk);
            #1;
        end
        rd = host_rdata[m];
        @(posedge clk);
        #1;
        host_req[m] = 1'b0;
        if (we) begin
            exp_mem[m][word][lane*8 +: 8] = wd;
            check(mem[m][word] === exp_mem[m][word],
                  $sformatf("%s m=%0d word %0d got %08h exp %08h", m == 0 ? "R7" : "R8 R9",
                  m, word, mem[m][word], exp_mem[m][word]));
        end else begin
            eb = exp_mem[m][word][lane*8 +: 8];
            check(rd === eb, $sformatf("R6 m=%0d read w%0d l%0d got %02h exp %02h",
                  m, word, lane, rd, eb));
        end
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            disp_en[m] = 0; host_req[m] = 0; host_we[m] = 0;
            host_addr[m] = '0; host_wdata[m] = '0; k[m] = 0;
            for (int a = 0; a < WORDS; a++) exp_mem[m][a] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        for (int m = 0; m < 2; m++) begin
            check(!pix_valid[m] && !host_ack[m] && !mem_req[m],
                  $sformatf("R3 reset m=%0d valid/ack/req got %0d%0d%0d exp 000",
                  m, pix_valid[m], host_ack[m], mem_req[m]));
        end
        for (int m = 0; m < 2; m++) begin
            // Load the frame with a distinct byte per lane.
            for (int w = 0; w < DW; w++)
                for (int l = 0; l < 4; l++)
                    host_op(m, 1, w, l, 8'(w * 16 + l * 3 + m * 7 + 1));
            for (int w = 0; w < DW; w++) host_op(m, 0, w, w % 4, 8'h00);
            host_op(m, 1, 3, 2, 8'hA5);
            host_op(m, 0, 3, 1, 8'h00);
            // Stream while the host works outside the frame at varying phases.
            @(negedge clk);
            disp_en[m] = 1'b1;
            fork
                begin
                    for (int i = 0; i < 48; i++) begin
                        repeat (i % 5) @(negedge clk);
                        host_op(m, (i % 3) != 2, DW + (i % (WORDS - DW)), i % 4, 8'(i * 7 + m));
                    end
                end
                begin
                    repeat (150) @(negedge clk);
                end
            join
            @(negedge clk);
            disp_en[m] = 1'b0;
            repeat (3) @(negedge clk);
            disp_en[m] = 1'b1;
            repeat (40) @(negedge clk);
            disp_en[m] = 1'b0;
            repeat (3) @(negedge clk);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule